// File: doc/BRIEF.md
# Eight-bit GPIO port with retention-aware resets

This block is an eight-bit general-purpose I/O port. A small memory-mapped bus reaches four byte-wide registers. The output latch sets the level driven onto each pad. The direction register picks output or input for each bit. The pull-up register requests a weak pull-up on each pad. The fourth register is read-only and shows the pin levels. Pad inputs pass through a two-flop synchronizer before they are read.

The port handles its four reset and standby inputs differently.

- A power-on reset clears everything, and so does hardware standby. After either one, every pin is an input with no pull-up.
- A manual reset keeps the register contents and the last sampled pin snapshot. Software standby does the same.
- Reading the pin register returns a value per bit. An output bit returns its latched data. An input bit returns the synchronized pin level.

Top module: `gpio_port8`

## Requirements
- R1: While `por_n` is low (asynchronous), the output latch, direction, pull-up and `bus_rdata` are all 0x00.
- R2: While `hw_stby` is 1, `pad_pu` is 0x00 at once. At every clock edge in that time, the output latch, direction and pull-up registers are cleared to 0x00.
- R3: While `mrst_n` is 0 or `sw_stby` is 1:
  - bus writes are ignored;
  - all registers keep their values;
  - the synchronizer stops sampling, so pin-register reads return the last snapshot.
- R4: The output latch is at offset 0x0 and can be read and written.
- R5: The direction register is at offset 0x2 and can be read and written. `pad_oe[i]` equals direction bit i, where 1 means output.
- R6: `pad_out[i]` equals output latch bit i.
- R7: On a read of offset 0x1, each bit whose direction bit is 1 returns its output latch bit.
- R8: On a read of offset 0x1, each bit whose direction bit is 0 returns `pad_in` through two flops. A pin change made before clock edge k is seen by a read taken at edge k+2, and is not seen by reads at edge k or k+1.
- R9: Writes to offset 0x1 change no register.
- R10: The pull-up register is at offset 0x3 and can be read and written. `pad_pu[i]` is 1 only when pull-up bit i is 1, direction bit i is 0 and `hw_stby` is 0.
- R11: `bus_rdata` is loaded at the clock edge where `bus_rd` is 1. It holds its value at edges where `bus_rd` is 0.
- R12: Reads of offsets 0x4 and above return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| mrst_n | input | 1 | Manual reset, active low; registers are kept |
| hw_stby | input | 1 | Hardware standby; clears registers and forces pull-ups off |
| sw_stby | input | 1 | Software standby; registers are kept |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears after the next edge |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| pad_in | input | W | Pad input levels |
| pad_oe | output | W | Pad output enables |
| pad_out | output | W | Pad output values |
| pad_pu | output | W | Pad pull-up requests |

## Verification
The bench reads the pin register with the direction set to a mixed pattern. A wrong readback mux would return either all latch data or all pin levels.

A pin change is read at three points: the first edge after the change, the second edge, and once it has settled. A synchronizer with the wrong depth would show the new level too early, or never show it.

Writes and pin changes are applied while manual reset is held, and again under software standby. A design that cleared its registers, or kept sampling the pins, would return fresh values instead of the retained ones.

Hardware standby is checked for three things: the pull-ups drop at once, the registers are cleared, and unused offsets still read zero.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          mrst_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu
);
  localparam logic [AW-1:0] OFS_DATA = AW'(0);
  localparam logic [AW-1:0] OFS_PINS = AW'(1);
  localparam logic [AW-1:0] OFS_DIR  = AW'(2);
  localparam logic [AW-1:0] OFS_PULL = AW'(3);

  logic [W-1:0] dout_q, dir_q, pull_q, meta_q, pins_q, rd_mux;
  logic hold, wen;

  assign hold = ~mrst_n | sw_stby;
  assign wen  = bus_wr & ~hold & ~hw_stby;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      pull_q <= '0;
    end else if (hw_stby) begin
      dout_q <= '0;
      dir_q  <= '0;
      pull_q <= '0;
    end else if (wen) begin
      case (bus_addr)
        OFS_DATA: dout_q <= bus_wdata;
        OFS_DIR:  dir_q  <= bus_wdata;
        OFS_PULL: pull_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= '0;
      pins_q <= '0;
    end else if (!hold) begin
      meta_q <= pad_in;
      pins_q <= meta_q;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DATA: rd_mux = dout_q;
      OFS_PINS: rd_mux = (dir_q & dout_q) | (~dir_q & pins_q);
      OFS_DIR:  rd_mux = dir_q;
      OFS_PULL: rd_mux = pull_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign pad_oe  = dir_q;
  assign pad_out = dout_q;
  assign pad_pu  = hw_stby ? '0 : (pull_q & ~dir_q);
endmodule

module gpio_port8_chk #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          por_n,
  input logic          mrst_n,
  input logic          hw_stby,
  input logic          sw_stby,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_pu
);
  logic live_wr;
  assign live_wr = bus_wr && mrst_n && !sw_stby && !hw_stby;

  p_data_write_r4: assert property (@(posedge clk) disable iff (!por_n)
    live_wr && bus_addr == AW'(0) |=> pad_out == $past(bus_wdata));
  p_dir_write_r5: assert property (@(posedge clk) disable iff (!por_n)
    live_wr && bus_addr == AW'(2) |=> pad_oe == $past(bus_wdata));
  p_pu_off_stby_r2: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |-> pad_pu == '0);
  p_stby_clears_r2: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |=> pad_oe == '0 && pad_out == '0);
  p_pu_inputs_only_r10: assert property (@(posedge clk) disable iff (!por_n)
    (pad_pu & pad_oe) == '0);
  p_retain_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n || sw_stby) && !hw_stby |=> $stable(pad_out) && $stable(pad_oe));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_port8 gpio_port8_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/sim_gpio_port8.sv
`timescale 1ns/1ps
module sim_gpio_port8;
  logic clk = 0, por_n = 0, mrst_n = 1, hw_stby = 0, sw_stby = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, pad_in = 8'hA5;
  logic [7:0] bus_rdata, pad_oe, pad_out, pad_pu;
  int applied = 0, bad = 0;

  always #2.5 clk = ~clk;

  gpio_port8 u0 (.*);

  // {wr, rd, addr[3:0], wdata[7:0], expected rdata[7:0]}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'h0, 8'h3C, 8'h00},
    {1'b0, 1'b1, 4'h0, 8'h00, 8'h3C},  // R4
    {1'b1, 1'b0, 4'h2, 8'h0F, 8'h00},
    {1'b0, 1'b1, 4'h2, 8'h00, 8'h0F},  // R5
    {1'b0, 1'b1, 4'h1, 8'h00, 8'hAC},  // R7 low nibble, R8 high nibble
    {1'b1, 1'b0, 4'h1, 8'hFF, 8'h00},  // R9 write to pin register
    {1'b0, 1'b1, 4'h0, 8'h00, 8'h3C},  // R9
    {1'b1, 1'b0, 4'h3, 8'hF0, 8'h00},
    {1'b0, 1'b1, 4'h3, 8'h00, 8'hF0},  // R10
    {1'b0, 1'b1, 4'h5, 8'h00, 8'h00},  // R12
    {1'b1, 1'b0, 4'h2, 8'h00, 8'h00},
    {1'b0, 1'b1, 4'h1, 8'h00, 8'hA5}   // R8
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [3:0] a, input logic [7:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    cyc(0, 1, a, 0);
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1", bus_rdata, 8'h00);
    chk("R1", pad_oe, 8'h00);
    chk("R1", pad_out, 8'h00);
    por_n = 1;
    repeat (3) @(negedge clk);

    foreach (VEC[i]) begin
      cyc(VEC[i][21], VEC[i][20], VEC[i][19:16], VEC[i][15:8]);
      if (VEC[i][20]) chk("R4/R5/R7/R8/R9/R10/R12", bus_rdata, VEC[i][7:0]);
    end

    // pads
    cyc(1, 0, 4'h0, 8'h5A);
    cyc(1, 0, 4'h2, 8'h0F);
    cyc(1, 0, 4'h3, 8'hFF);
    chk("R6", pad_out, 8'h5A);
    chk("R5", pad_oe, 8'h0F);
    chk("R10", pad_pu, 8'hF0);

    // R11: rdata holds without a read strobe
    rd_chk("R11", 4'h0, 8'h5A);
    cyc(1, 0, 4'h0, 8'h11);
    cyc(0, 0, 4'h2, 8'h00);
    chk("R11", bus_rdata, 8'h5A);

    // R8: synchronizer depth, direction all inputs
    cyc(1, 0, 4'h2, 8'h00);
    pad_in = 8'h3C;
    rd_chk("R8 edge k", 4'h1, 8'hA5);
    rd_chk("R8 edge k+1", 4'h1, 8'hA5);
    rd_chk("R8 edge k+2", 4'h1, 8'h3C);

    // R3: manual reset retention
    cyc(1, 0, 4'h0, 8'h77);
    mrst_n = 0;
    pad_in = 8'hC3;
    cyc(1, 0, 4'h0, 8'h22);
    repeat (3) @(negedge clk);
    rd_chk("R3 mrst data", 4'h0, 8'h77);
    rd_chk("R3 mrst pins", 4'h1, 8'h3C);
    mrst_n = 1;
    repeat (3) @(negedge clk);
    rd_chk("R3 after mrst", 4'h1, 8'hC3);

    // R3: software standby retention
    sw_stby = 1;
    pad_in = 8'h0F;
    cyc(1, 0, 4'h2, 8'hFF);
    repeat (3) @(negedge clk);
    rd_chk("R3 sstby dir", 4'h2, 8'h00);
    rd_chk("R3 sstby pins", 4'h1, 8'hC3);
    sw_stby = 0;
    repeat (3) @(negedge clk);

    // R2: hardware standby
    cyc(1, 0, 4'h3, 8'hFF);
    cyc(1, 0, 4'h2, 8'h01);
    chk("R10", pad_pu, 8'hFE);
    hw_stby = 1;
    #1;
    chk("R2 pu immediate", pad_pu, 8'h00);
    @(negedge clk);
    chk("R2 oe", pad_oe, 8'h00);
    chk("R2 out", pad_out, 8'h00);
    hw_stby = 0;
    rd_chk("R2 pull cleared", 4'h3, 8'h00);
    rd_chk("R12", 4'hF, 8'h00);

    // R1: power-on reset mid-run
    cyc(1, 0, 4'h0, 8'h99);
    rd_chk("R4", 4'h0, 8'h99);
    por_n = 0;
    #1;
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    @(negedge clk);
    por_n = 1;
    @(negedge clk);
    rd_chk("R1 data", 4'h0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule